// File: doc/BRIEF.md
# Two-Wire Write-Byte DAC Code Receiver

This block is a receive-only slave on a two-wire SMBus/I2C bus. It oversamples SCL and SDA with a fast system clock, detects START and STOP, and accepts the Write Byte transaction: a 7-bit device address with the write bit, then a command byte, then a data byte. It acknowledges each byte by pulling SDA low. The block never sends data and never stretches the clock.

The command byte carries a power-down request in its top bit and the two most significant bits of a 10-bit converter code in its two lowest bits. These three bits go into a holding latch when the command byte's acknowledge ends. When the data byte's acknowledge ends, the held bits and the data byte are loaded into the 10-bit code register together, and the power-down latch is loaded at the same time. Two strap pins select one of four bus addresses and the code loaded at reset. An active-low power-down input forces the power-down output high without disturbing the stored code.

Top module: `smb_dac_slave`

## Requirements
- R1: The device address is 0101 1xy, where the low pair xy comes from the straps (addr_sel1, addr_sel0): (0,0) gives 01, (0,1) gives 11, (1,0) gives 10 and (1,1) gives 00. A matching address byte sent with write bit 0 is acknowledged.
- R2: An address byte that does not match, or that carries read bit 1, is not acknowledged. All later bytes up to the next START or STOP are also not acknowledged and have no effect on the outputs.
- R3: An acknowledge holds sda_oe high from the falling SCL edge after the eighth bit of a byte until the falling SCL edge after the ninth bit.
- R4: When the command byte's acknowledge ends, bit 7 (power-down request) and bits 1:0 (code bits 9:8) are held. Bits 6:2 of the command byte have no effect.
- R5: When the data byte's acknowledge ends, dac_code becomes {held bits 1:0, data byte} and the power-down latch takes the held bit 7. Both change in the same clock, four system clocks after SCL falls.
- R6: After reset, dac_code is 10'h200 when both straps are high and 10'h000 otherwise, and the power-down latch is clear.
- R7: dac_shutdown is high when pwr_down_n is low or the power-down latch is set. dac_code keeps its value while dac_shutdown is high.
- R8: A transaction that is cut short by STOP or START before its final acknowledge leaves dac_code and the power-down latch unchanged.
- R9: A repeated START at any point restarts address reception, and the transaction that follows completes normally.
- R10: Bytes after the final acknowledge are not acknowledged and have no effect. A STOP is optional: a new START right after the final acknowledge begins a new transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as observed |
| sda_i | input | 1 | Bus data line as observed (wired-AND with the master) |
| sda_oe | output | 1 | High pulls SDA low to acknowledge |
| addr_sel1 | input | 1 | Address/default strap, upper |
| addr_sel0 | input | 1 | Address/default strap, lower |
| pwr_down_n | input | 1 | Active-low power-down request pin |
| dac_code | output | 10 | Committed converter code |
| dac_shutdown | output | 1 | Converter power-down output |

## Verification
The assertions assume that SCL and SDA never change in the same or adjacent system clock, so that each data bit, START and STOP is seen as a clean edge after synchronization. They also assume that the master leaves SDA alone while the slave acknowledges and SCL is high. The bench keeps every SCL phase 16 system clocks long and moves SDA only in the middle of the SCL low phase, except when it forms START or STOP while SCL is high. It releases SDA during each ninth bit. The straps change only while reset is asserted.

// File: rtl/smbdac_pkg.sv
// Package: shared types and helpers for the two-wire DAC code receiver.
// Assumes a 7-bit address whose upper five bits are fixed per device family.
package smbdac_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [2:0] {
        RX_IDLE = 3'd0,
        RX_ADDR = 3'd1,
        RX_CMD  = 3'd2,
        RX_DATA = 3'd3,
        RX_SKIP = 3'd4
    } rx_state_t;

    // Maps the strap pair to the two low address bits.
    function automatic logic [1:0] strap_to_addr_lo(input logic sel1, input logic sel0);
        strap_to_addr_lo = {sel1 ^ sel0, ~sel1};
    endfunction

endpackage

// File: rtl/smbdac_sync.sv
// Bus line synchronizer and condition detector.
// Passes SCL and SDA through STAGES flops and keeps one extra sample of each
// to find SCL edges and START/STOP. Assumes SCL and SDA never toggle together.
module smbdac_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;
    logic              scl_now;

    // Synchronizer chains; idle bus lines read high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
    end

    // One-cycle-old copies for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_ff[STAGES-1];
            sda_q <= sda_ff[STAGES-1];
        end
    end

    // Edge and bus-condition decode.
    always_comb begin
        scl_now   = scl_ff[STAGES-1];
        sda_s     = sda_ff[STAGES-1];
        scl_rise  = scl_now & ~scl_q;
        scl_fall  = ~scl_now & scl_q;
        start_det = scl_now & scl_q & sda_q & ~sda_s;
        stop_det  = scl_now & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/smbdac_rx.sv
// Receive sequencer for the Write Byte transaction.
// Shifts in bits on rising SCL, drives acknowledges between falling SCL
// edges, and pulses hold_load / commit when the command or data byte's
// acknowledge ends. Assumes clean edge strobes from smbdac_sync.
module smbdac_rx
    import smbdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [ADDR_W-1:0] dev_addr,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              hold_load,
    output logic              commit
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

    rx_state_t         state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              acking;
    logic              receiving;
    logic              addr_ok;

    // Decode whether a byte is being received and whether the address matches.
    always_comb begin
        receiving = (state == RX_ADDR) || (state == RX_CMD) || (state == RX_DATA);
        addr_ok   = (shreg == {dev_addr, 1'b0});
        rx_byte   = shreg;
    end

    // Main sequencer: bit capture, acknowledge window and byte hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            acking    <= 1'b0;
            sda_oe    <= 1'b0;
            hold_load <= 1'b0;
            commit    <= 1'b0;
        end else begin
            hold_load <= 1'b0;
            commit    <= 1'b0;
            if (start_det) begin
                state   <= RX_ADDR;
                bit_cnt <= '0;
                acking  <= 1'b0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state   <= RX_IDLE;
                bit_cnt <= '0;
                acking  <= 1'b0;
                sda_oe  <= 1'b0;
            end else if (receiving) begin
                if (scl_rise && !acking && (bit_cnt != CNT_FULL)) begin
                    shreg   <= {shreg[BYTE_W-2:0], sda_s};
                    bit_cnt <= bit_cnt + 1'b1;
                end else if (scl_fall && acking) begin
                    acking  <= 1'b0;
                    sda_oe  <= 1'b0;
                    bit_cnt <= '0;
                    unique case (state)
                        RX_ADDR: state <= RX_CMD;
                        RX_CMD: begin
                            state     <= RX_DATA;
                            hold_load <= 1'b1;
                        end
                        RX_DATA: begin
                            state  <= RX_SKIP;
                            commit <= 1'b1;
                        end
                        default: state <= RX_SKIP;
                    endcase
                end else if (scl_fall && (bit_cnt == CNT_FULL)) begin
                    if ((state == RX_ADDR) && !addr_ok) begin
                        state <= RX_SKIP;
                    end else begin
                        acking <= 1'b1;
                        sda_oe <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/smbdac_regs.sv
// Two-stage code staging: a holding latch for the command byte's control
// bits and the committed code / power-down latch. Assumes hold_load and
// commit are single-cycle strobes and rx_byte is stable while they are high.
module smbdac_regs #(
    parameter int CODE_W = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mid_default,
    input  logic              hold_load,
    input  logic              commit,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              pwr_down_n,
    output logic [CODE_W-1:0] code,
    output logic              shut_lat,
    output logic              shutdown
);

    localparam int MSB_W = CODE_W - BYTE_W;
    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

    logic [MSB_W-1:0] hold_msb;
    logic             hold_sd;

    // Holding latch loaded at the end of the command byte's acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_msb <= '0;
            hold_sd  <= 1'b0;
        end else if (hold_load) begin
            hold_msb <= rx_byte[MSB_W-1:0];
            hold_sd  <= rx_byte[BYTE_W-1];
        end
    end

    // Committed code and power-down latch, loaded together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code     <= mid_default ? MID_CODE : '0;
            shut_lat <= 1'b0;
        end else if (commit) begin
            code     <= {hold_msb, rx_byte};
            shut_lat <= hold_sd;
        end
    end

    // Power-down output: pin or latched request.
    always_comb begin
        shutdown = ~pwr_down_n | shut_lat;
    end

endmodule

// File: rtl/smb_dac_slave.sv
// Top: receive-only two-wire slave driving a 10-bit DAC code.
// Assumes straps are static while out of reset and SCL is slow compared
// with clk (several clocks per SCL phase).
module smb_dac_slave
    import smbdac_pkg::*;
#(
    parameter int            CODE_W      = 10,
    parameter int            SYNC_STAGES = 2,
    parameter logic [4:0]    ADDR_HI     = 5'b01011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              addr_sel1,
    input  logic              addr_sel0,
    input  logic              pwr_down_n,
    output logic [CODE_W-1:0] dac_code,
    output logic              dac_shutdown
);

    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic [ADDR_W-1:0] dev_addr;
    logic              mid_default;
    logic [BYTE_W-1:0] rx_byte;
    logic              hold_load;
    logic              commit;
    logic              shut_lat;

    // Strap decode: address and reset default.
    always_comb begin
        dev_addr    = {ADDR_HI, strap_to_addr_lo(addr_sel1, addr_sel0)};
        mid_default = addr_sel1 & addr_sel0;
    end

    smbdac_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smbdac_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .dev_addr  (dev_addr),
        .sda_oe    (sda_oe),
        .rx_byte   (rx_byte),
        .hold_load (hold_load),
        .commit    (commit)
    );

    smbdac_regs #(
        .CODE_W (CODE_W),
        .BYTE_W (BYTE_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .mid_default (mid_default),
        .hold_load   (hold_load),
        .commit      (commit),
        .rx_byte     (rx_byte),
        .pwr_down_n  (pwr_down_n),
        .code        (dac_code),
        .shut_lat    (shut_lat),
        .shutdown    (dac_shutdown)
    );

endmodule

// File: rtl/smbdac_chk.sv
// Checker for smb_dac_slave, attached by bind. Assumes the master keeps
// SDA still while the slave acknowledges with SCL high.
module smbdac_chk #(
    parameter int CODE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic              scl_fall,
    input logic              start_det,
    input logic              stop_det,
    input logic              hold_load,
    input logic              commit,
    input logic [CODE_W-1:0] dac_code,
    input logic              shut_lat
);

    // R3: acknowledge opens only just after a falling SCL edge.
    a_r3_ack_opens_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    // R3: acknowledge stays until a falling SCL edge (or bus condition).
    a_r3_ack_held_to_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe && !scl_fall && !start_det && !stop_det) |=> sda_oe);

    // R5: commit happens exactly as an acknowledge closes.
    a_r5_commit_ends_ack: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (!sda_oe && $past(sda_oe)));

    // R4: the holding latch and commit are never strobed together.
    a_r4_hold_apart_from_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold_load && commit));

    // R8: the code moves only after a commit strobe.
    a_r8_code_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(dac_code));

    // R8: the power-down latch moves only after a commit strobe.
    a_r8_shut_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(shut_lat));

endmodule

bind smb_dac_slave smbdac_chk #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .hold_load (hold_load),
    .commit    (commit),
    .dac_code  (dac_code),
    .shut_lat  (shut_lat)
);

// File: tb/smb_dac_slave_tb.sv
// Bench: behavioural bus master plus a queued reference model of the code
// and power-down outputs, compared every clock.
module smb_dac_slave_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sel1 = 1'b1;
    logic       sel0 = 1'b1;
    logic       pd_n = 1'b1;
    logic       sda_oe;
    logic [9:0] dac_code;
    logic       dac_shutdown;
    logic       sda_line;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // Reference model state
    logic [9:0] mdl_code = 10'h200;
    logic       mdl_sd = 1'b0;
    logic [1:0] mdl_hmsb = 2'b00;
    logic       mdl_hsd = 1'b0;
    int         q_due[$];
    logic [9:0] q_code[$];
    logic       q_sd[$];

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    smb_dac_slave u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .sda_oe       (sda_oe),
        .addr_sel1    (sel1),
        .addr_sel0    (sel0),
        .pwr_down_n   (pd_n),
        .dac_code     (dac_code),
        .dac_shutdown (dac_shutdown)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison with the model, 5 ns after each rising edge.
    always begin
        @(posedge clk);
        #5;
        if (rst_n) begin
            while (q_due.size() > 0 && q_due[0] <= cyc) begin
                void'(q_due.pop_front());
                mdl_code = q_code.pop_front();
                mdl_sd   = q_sd.pop_front();
            end
            chk(dac_code == mdl_code, "R5/R8 per-clock code", dac_code, mdl_code);
            chk(dac_shutdown == (!pd_n || mdl_sd), "R7 per-clock shutdown",
                dac_shutdown, (!pd_n || mdl_sd));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start();
        sda_m = 1'b1; tick(8);
        scl_m = 1'b1; tick(16);
        sda_m = 1'b0; tick(16);
        scl_m = 1'b0; tick(8);
    endtask

    task automatic do_stop();
        sda_m = 1'b0; tick(8);
        scl_m = 1'b1; tick(16);
        sda_m = 1'b1; tick(16);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked, output int fall_cyc);
        for (int i = 7; i >= 0; i--) begin
            tick(8); sda_m = b[i];
            tick(8); scl_m = 1'b1;
            tick(16); scl_m = 1'b0;
        end
        tick(8); sda_m = 1'b1;
        tick(8); scl_m = 1'b1;
        tick(8); acked = !sda_line;
        tick(8); scl_m = 1'b0;
        fall_cyc = cyc;
    endtask

    function automatic logic [6:0] bench_addr(input logic s1, input logic s0);
        case ({s1, s0})
            2'b00:   bench_addr = 7'b0101101;
            2'b01:   bench_addr = 7'b0101111;
            2'b10:   bench_addr = 7'b0101110;
            default: bench_addr = 7'b0101100;
        endcase
    endfunction

    // Address + command + data, model updated at each acknowledge end.
    task automatic write_tx(input logic [6:0] a, input logic rw, input logic [7:0] c,
                            input logic [7:0] d, input bit want_ack, input bit end_stop,
                            input string tag);
        bit ak;
        int fc;
        do_start();
        send_byte({a, rw}, ak, fc);
        chk(ak == want_ack, {tag, " address ack"}, ak, want_ack);
        send_byte(c, ak, fc);
        chk(ak == want_ack, {tag, " command ack"}, ak, want_ack);
        if (ak) begin
            mdl_hmsb = c[1:0];
            mdl_hsd  = c[7];
        end
        send_byte(d, ak, fc);
        chk(ak == want_ack, {tag, " data ack"}, ak, want_ack);
        if (ak) begin
            q_due.push_back(fc + 4);
            q_code.push_back({mdl_hmsb, d});
            q_sd.push_back(mdl_hsd);
        end
        if (end_stop) do_stop();
        tick(10);
    endtask

    task automatic do_reset(input logic s1, input logic s0);
        rst_n = 1'b0;
        sel1 = s1;
        sel0 = s0;
        scl_m = 1'b1;
        sda_m = 1'b1;
        tick(5);
        q_due.delete();
        q_code.delete();
        q_sd.delete();
        mdl_code = (s1 && s0) ? 10'h200 : 10'h000;
        mdl_sd = 1'b0;
        rst_n = 1'b1;
        tick(3);
    endtask

    initial begin
        bit ak;
        int fc;

        // R6: reset with both straps high gives mid-scale
        do_reset(1'b1, 1'b1);
        chk(dac_code == 10'h200, "R6 mid-scale reset", dac_code, 10'h200);
        chk(dac_shutdown == 1'b0, "R6 shutdown clear", dac_shutdown, 0);
        chk(sda_oe == 1'b0, "R3 no ack at reset", sda_oe, 0);

        // R1 R4 R5: write with junk in command bits 6:2
        write_tx(7'b0101100, 1'b0, 8'h56, 8'h5A, 1'b1, 1'b1, "R1");
        chk(dac_code == 10'h25A, "R4 R5 code commit", dac_code, 10'h25A);

        // R2: wrong address, then read bit
        write_tx(7'b0101111, 1'b0, 8'h03, 8'hFF, 1'b0, 1'b1, "R2 wrong address");
        chk(dac_code == 10'h25A, "R2 ignored after mismatch", dac_code, 10'h25A);
        write_tx(7'b0101100, 1'b1, 8'h03, 8'hFF, 1'b0, 1'b1, "R2 read bit");
        chk(dac_code == 10'h25A, "R2 ignored after read", dac_code, 10'h25A);

        // R5 R7: power-down via command bit 7
        write_tx(7'b0101100, 1'b0, 8'h81, 8'h33, 1'b1, 1'b1, "R5");
        chk(dac_code == 10'h133, "R5 code with power-down", dac_code, 10'h133);
        chk(dac_shutdown == 1'b1, "R7 latched power-down", dac_shutdown, 1);
        write_tx(7'b0101100, 1'b0, 8'h7F, 8'hFF, 1'b1, 1'b1, "R4");
        chk(dac_code == 10'h3FF, "R4 bits 6:2 ignored", dac_code, 10'h3FF);
        chk(dac_shutdown == 1'b0, "R5 power-down cleared", dac_shutdown, 0);

        // R7: pin power-down keeps the code
        pd_n = 1'b0; tick(20);
        chk(dac_shutdown == 1'b1, "R7 pin power-down", dac_shutdown, 1);
        chk(dac_code == 10'h3FF, "R7 code retained", dac_code, 10'h3FF);
        pd_n = 1'b1; tick(4);
        chk(dac_shutdown == 1'b0, "R7 pin released", dac_shutdown, 0);

        // R8: STOP after command byte leaves outputs alone
        do_start();
        send_byte({7'b0101100, 1'b0}, ak, fc);
        send_byte(8'h80, ak, fc);
        chk(ak == 1'b1, "R8 command ack", ak, 1);
        do_stop(); tick(10);
        chk(dac_code == 10'h3FF, "R8 abort code", dac_code, 10'h3FF);
        chk(dac_shutdown == 1'b0, "R8 abort shutdown", dac_shutdown, 0);

        // R9: repeated START after command byte restarts reception
        do_start();
        send_byte({7'b0101100, 1'b0}, ak, fc);
        send_byte(8'h82, ak, fc);
        write_tx(7'b0101100, 1'b0, 8'h01, 8'h10, 1'b1, 1'b0, "R9");
        chk(dac_code == 10'h110, "R9 restart commit", dac_code, 10'h110);

        // R10: extra byte not acknowledged, then START without STOP
        send_byte(8'hAA, ak, fc);
        chk(ak == 1'b0, "R10 extra byte nack", ak, 0);
        tick(10);
        chk(dac_code == 10'h110, "R10 extra byte no effect", dac_code, 10'h110);
        write_tx(7'b0101100, 1'b0, 8'h00, 8'h07, 1'b1, 1'b1, "R10");
        chk(dac_code == 10'h007, "R10 start without stop", dac_code, 10'h007);

        // R1 R6: the other strap settings
        for (int s = 0; s < 3; s++) begin
            logic s1;
            logic s0;
            s1 = (s == 2);
            s0 = (s == 1);
            do_reset(s1, s0);
            chk(dac_code == 10'h000, "R6 zero-scale reset", dac_code, 0);
            write_tx(7'b0101100, 1'b0, 8'h02, 8'h01, 1'b0, 1'b1, "R1 old address");
            write_tx(bench_addr(s1, s0), 1'b0, 8'h02, 8'h01, 1'b1, 1'b1, "R1 strap address");
            chk(dac_code == 10'h201, "R1 strap write", dac_code, 10'h201);
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule